// File: doc/BRIEF.md
# Lane Receive-PLL Override Sequencer

This block runs the per-lane override routine that a serial PHY lane needs on either side of a link hard reset. It talks to the PHY only through a register access port. It sends read and write commands on a valid/ready command channel and takes read data back on a valid/ready response channel. Two start strobes select one of two jobs. The release job reads the lane input status word, drops the override-enable bit and writes the result to the lane override register. The force job waits for the lane to leave half-rate. It then steps the override register through a fixed chain of five writes that ends with a chosen receive-PLL mode and a pulsed PLL reset, and it holds off completion for a settle time.

Each written word comes from the previous one, so after the status read the register is never read again. The half-rate wait gives up after a set number of reads. When that happens a sticky flag is raised and the sequence goes on regardless. `done` pulses once when a job is finished.

Back-pressure: a command is transferred on a cycle where `cmd_valid` and `cmd_ready` are both high. While `cmd_valid` is high and `cmd_ready` is low, the command fields do not change. Only one read is ever outstanding. `rsp_ready` is high only while the block waits for read data, and no command is offered during that time. The responder may hold `rsp_valid` back for any number of cycles.

Top module: `lane_pll_ovr`

## Requirements
- R1: Register addresses are formed from the lane index placed at address bits [9:8]. The status register is 0x2002 + lane*0x100 and the override register is 0x2005 + lane*0x100. Reads go only to the status register and writes go only to the override register.
- R2: The release job issues exactly one status read, then one override write carrying the read word with bit 14 cleared and every other bit unchanged. `done` pulses in the cycle after that write is accepted.
- R3: The force job reads the status register again and again while bit 0 (half-rate) of the returned word is 1. It stops after the first read with bit 0 clear, or after POLL_LIMIT reads, whichever comes first.
- R4: If the POLL_LIMIT-th poll read still shows half-rate, `poll_timeout` goes to 1 and the sequence carries on. The flag stays at 1 until the next job is accepted, which clears it.
- R5: After polling, the force job issues one more status read, giving a word W. It then issues five override writes in this order: W with bit 14 cleared; that word with bit 14 set; that word with bits [10:8] replaced by the mode; that word with bit 11 set; that word with bit 11 cleared.
- R6: The mode written into bits [10:8] and the lane used are the values present on `mode` and `lane` when the job was accepted.
- R7: After the last force write is accepted, no command is offered for SETTLE_CYCLES cycles. `done` is then high for exactly one cycle, in cycle SETTLE_CYCLES+1 counted from the accepting edge.
- R8: A command held under back-pressure keeps its address, direction and data. `rsp_ready` and `cmd_valid` are never high together.
- R9: Start strobes are ignored while a job is in progress. If both strobes are high together, the force job is started.
- R10: After reset, `cmd_valid`, `rsp_ready`, `done` and `poll_timeout` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_release | input | 1 | Start the override-release job |
| start_force | input | 1 | Start the half-rate wait and mode-force job |
| lane | input | LANE_W | Lane index, sampled at start |
| mode | input | MODE_W | Receive-PLL mode, sampled at start |
| done | output | 1 | One-cycle job-complete pulse |
| poll_timeout | output | 1 | Sticky: half-rate wait hit its read limit |
| cmd_valid | output | 1 | Command offered |
| cmd_ready | input | 1 | Command accepted this cycle |
| cmd_write | output | 1 | 1 = write, 0 = read |
| cmd_addr | output | ADDR_W | Register address |
| cmd_wdata | output | DATA_W | Write data (0 on reads) |
| rsp_valid | input | 1 | Read data present |
| rsp_ready | output | 1 | Block is waiting for read data |
| rsp_data | input | DATA_W | Read data |

## Verification
Each command is visible on the port in the cycle after the handshake that ends the previous step. A read response is taken in the first cycle where `rsp_valid` meets `rsp_ready`. A release job's `done` appears one cycle after its write is accepted, and a force job's `done` appears SETTLE_CYCLES+1 cycles after its last write is accepted. The bench records every handshake and every `done` pulse against a free-running cycle count taken at the rising edge, then compares those cycle distances, not fixed delays from the start strobe. Command contents are checked against a log, so stalls from the alternating ready pattern do not move any expected value.

// File: rtl/lov_pkg.sv
package lov_pkg;
  localparam int STS_BASE     = 'h2002;
  localparam int OVR_BASE     = 'h2005;
  localparam int LANE_SHIFT   = 8;
  localparam int HR_BIT       = 0;
  localparam int OVR_EN_BIT   = 14;
  localparam int PLL_RST_BIT  = 11;
  localparam int MODE_LSB     = 8;
  localparam int NUM_WR_STEPS = 5;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_REQ,
    ST_RD_WAIT,
    ST_WR_REQ,
    ST_SETTLE
  } lov_state_e;
endpackage

// File: rtl/lov_addr.sv
module lov_addr #(
  parameter int ADDR_W = 16,
  parameter int LANE_W = 2
) (
  input  logic [LANE_W-1:0] lane,
  output logic [ADDR_W-1:0] sts_addr,
  output logic [ADDR_W-1:0] ovr_addr
);
  import lov_pkg::*;
  localparam logic [ADDR_W-1:0] STS_B = ADDR_W'(STS_BASE);
  localparam logic [ADDR_W-1:0] OVR_B = ADDR_W'(OVR_BASE);

  logic [ADDR_W-1:0] lane_off;
  assign lane_off = ADDR_W'(lane) << LANE_SHIFT;
  assign sts_addr = STS_B + lane_off;
  assign ovr_addr = OVR_B + lane_off;
endmodule

// File: rtl/lov_word_step.sv
module lov_word_step #(
  parameter int DATA_W = 16,
  parameter int MODE_W = 3
) (
  input  logic [DATA_W-1:0] cur,
  input  logic [2:0]        step,
  input  logic [MODE_W-1:0] mode,
  output logic [DATA_W-1:0] nxt
);
  import lov_pkg::*;
  // Word that the write after step 'step' must carry.
  always_comb begin
    nxt = cur;
    case (step)
      3'd0: nxt[OVR_EN_BIT] = 1'b1;
      3'd1: nxt[MODE_LSB +: MODE_W] = mode;
      3'd2: nxt[PLL_RST_BIT] = 1'b1;
      3'd3: nxt[PLL_RST_BIT] = 1'b0;
      default: nxt = cur;
    endcase
  end
endmodule

// File: rtl/lov_counter.sv
module lov_counter #(
  parameter int LIMIT = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic last
);
  localparam int W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [W-1:0] LAST_V = W'(LIMIT - 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) cnt <= '0;
    else if (inc && !last) cnt <= cnt + 1'b1;
  end

  assign last = (cnt == LAST_V);

  // Counter never passes its limit (bounds the poll count of R3 and settle of R7)
  p_cnt_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST_V);
endmodule

// File: rtl/lane_pll_ovr.sv
module lane_pll_ovr #(
  parameter int ADDR_W        = 16,
  parameter int DATA_W        = 16,
  parameter int LANE_W        = 2,
  parameter int MODE_W        = 3,
  parameter int POLL_LIMIT    = 1000,
  parameter int SETTLE_CYCLES = 3000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_release,
  input  logic              start_force,
  input  logic [LANE_W-1:0] lane,
  input  logic [MODE_W-1:0] mode,
  output logic              done,
  output logic              poll_timeout,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic              cmd_write,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [DATA_W-1:0] cmd_wdata,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic [DATA_W-1:0] rsp_data
);
  import lov_pkg::*;
  localparam logic [2:0] LAST_STEP = 3'(NUM_WR_STEPS - 1);

  lov_state_e        state;
  logic [LANE_W-1:0] lane_q;
  logic [MODE_W-1:0] mode_q;
  logic              job_force_q;
  logic              polling_q;
  logic [2:0]        step_q;
  logic [DATA_W-1:0] word_q;
  logic [DATA_W-1:0] word_nxt;
  logic [ADDR_W-1:0] sts_addr, ovr_addr;
  logic              done_q, timeout_q;
  logic              poll_last, settle_last, poll_inc;
  logic              start_any, rd_fire, wr_fire;

  lov_addr #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_addr (
    .lane(lane_q), .sts_addr(sts_addr), .ovr_addr(ovr_addr));

  lov_word_step #(.DATA_W(DATA_W), .MODE_W(MODE_W)) u_step (
    .cur(word_q), .step(step_q), .mode(mode_q), .nxt(word_nxt));

  lov_counter #(.LIMIT(POLL_LIMIT)) u_poll (
    .clk(clk), .rst_n(rst_n), .clr(state == ST_IDLE), .inc(poll_inc),
    .last(poll_last));

  lov_counter #(.LIMIT(SETTLE_CYCLES)) u_settle (
    .clk(clk), .rst_n(rst_n), .clr(state != ST_SETTLE),
    .inc(state == ST_SETTLE), .last(settle_last));

  assign start_any = start_force | start_release;
  assign rd_fire   = (state == ST_RD_WAIT) && rsp_valid;
  assign wr_fire   = (state == ST_WR_REQ) && cmd_ready;
  assign poll_inc  = rd_fire && polling_q && rsp_data[HR_BIT] && !poll_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      lane_q      <= '0;
      mode_q      <= '0;
      job_force_q <= 1'b0;
      polling_q   <= 1'b0;
      step_q      <= '0;
      word_q      <= '0;
      done_q      <= 1'b0;
      timeout_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state)
        ST_IDLE: if (start_any) begin
          lane_q      <= lane;
          mode_q      <= mode;
          job_force_q <= start_force;
          polling_q   <= start_force;
          timeout_q   <= 1'b0;
          state       <= ST_RD_REQ;
        end
        ST_RD_REQ: if (cmd_ready) state <= ST_RD_WAIT;
        ST_RD_WAIT: if (rsp_valid) begin
          if (polling_q) begin
            if (!rsp_data[HR_BIT]) begin
              polling_q <= 1'b0;
            end else if (poll_last) begin
              polling_q <= 1'b0;
              timeout_q <= 1'b1;
            end
            state <= ST_RD_REQ;
          end else begin
            word_q              <= rsp_data;
            word_q[OVR_EN_BIT]  <= 1'b0;
            step_q              <= '0;
            state               <= ST_WR_REQ;
          end
        end
        ST_WR_REQ: if (wr_fire) begin
          if (!job_force_q) begin
            done_q <= 1'b1;
            state  <= ST_IDLE;
          end else if (step_q == LAST_STEP) begin
            state <= ST_SETTLE;
          end else begin
            word_q <= word_nxt;
            step_q <= step_q + 1'b1;
          end
        end
        ST_SETTLE: if (settle_last) begin
          done_q <= 1'b1;
          state  <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign cmd_valid    = (state == ST_RD_REQ) || (state == ST_WR_REQ);
  assign cmd_write    = (state == ST_WR_REQ);
  assign cmd_addr     = (state == ST_WR_REQ) ? ovr_addr : sts_addr;
  assign cmd_wdata    = (state == ST_WR_REQ) ? word_q : '0;
  assign rsp_ready    = (state == ST_RD_WAIT);
  assign done         = done_q;
  assign poll_timeout = timeout_q;

  // R8: command held stable under back-pressure
  p_cmd_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_addr) &&
    $stable(cmd_write) && $stable(cmd_wdata));

  // R8: never waiting on data while offering a command
  p_one_outstanding_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ready |-> !cmd_valid);

  // R7: done is a single-cycle pulse
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9: captured lane and mode do not move during a job
  p_job_regs_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    state != ST_IDLE |=> $stable(lane_q) && $stable(mode_q));

  // R1: lane index appears at the lane field of every address
  p_addr_lane_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> cmd_addr[LANE_SHIFT +: LANE_W] == lane_q);

  // R6: third force write carries the captured mode
  p_mode_field_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_write && job_force_q && step_q == 3'd2 |->
    cmd_wdata[MODE_LSB +: MODE_W] == mode_q);

  // R6: reset bit high on the fourth write, low on the fifth
  p_rst_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_write && job_force_q && step_q >= 3'd3 |->
    cmd_wdata[PLL_RST_BIT] == (step_q == 3'd3));

  // R4: timeout flag is sticky for the rest of the job
  p_timeout_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    poll_timeout && state != ST_IDLE |=> poll_timeout);
endmodule

// File: tb/sim_lane_pll_ovr.sv
`timescale 1ns/1ps
module sim_lane_pll_ovr;
  localparam int PL = 8;
  localparam int ST = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_release = 1'b0, start_force = 1'b0;
  logic [1:0] lane = '0;
  logic [2:0] mode = '0;
  logic done, poll_timeout, cmd_valid, cmd_write, rsp_ready;
  logic cmd_ready = 1'b0;
  logic rsp_valid = 1'b0;
  logic [15:0] cmd_addr, cmd_wdata;
  logic [15:0] rsp_data = '0;

  always #2.5 clk = ~clk;

  lane_pll_ovr #(.POLL_LIMIT(PL), .SETTLE_CYCLES(ST)) u0 (
    .clk(clk), .rst_n(rst_n), .start_release(start_release),
    .start_force(start_force), .lane(lane), .mode(mode), .done(done),
    .poll_timeout(poll_timeout), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_write(cmd_write), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data));

  // Bench-side PHY model and handshake log
  logic        lg_wr   [0:511];
  logic [15:0] lg_addr [0:511];
  logic [15:0] lg_data [0:511];
  int          lg_cyc  [0:511];
  int lg_n = 0, cyc = 0, rd_seen = 0, done_cnt = 0, done_cyc = 0, hold_err = 0;
  int hr_limit = 0;
  logic [15:0] stat_word = '0;
  bit rdy_toggle = 1'b0;
  bit hold_pend = 1'b0;
  logic [32:0] prev_cmd = '0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      cmd_ready <= 1'b0;
      rsp_valid <= 1'b0;
      hold_pend <= 1'b0;
    end else begin
      cmd_ready <= rdy_toggle ? ~cmd_ready : 1'b1;
      if (rsp_valid && rsp_ready) rsp_valid <= 1'b0;
      if (cmd_valid && cmd_ready) begin
        lg_wr[lg_n]   <= cmd_write;
        lg_addr[lg_n] <= cmd_addr;
        lg_data[lg_n] <= cmd_wdata;
        lg_cyc[lg_n]  <= cyc;
        lg_n <= lg_n + 1;
        if (!cmd_write) begin
          rsp_valid <= 1'b1;
          rsp_data  <= {stat_word[15:1], (rd_seen < hr_limit)};
          rd_seen   <= rd_seen + 1;
        end
      end
      if (hold_pend && !(cmd_valid && prev_cmd == {cmd_write, cmd_addr, cmd_wdata}))
        hold_err <= hold_err + 1;
      hold_pend <= cmd_valid && !cmd_ready;
      prev_cmd  <= {cmd_write, cmd_addr, cmd_wdata};
      if (done) begin
        done_cnt <= done_cnt + 1;
        done_cyc <= cyc;
      end
    end
  end

  int nchk = 0, nfail = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_done(input int prev);
    int n = 0;
    while (done_cnt == prev && n < 3000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(!cmd_valid && !rsp_ready && !done && !poll_timeout, "R10 reset outputs",
        {cmd_valid, rsp_ready, done, poll_timeout}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!cmd_valid && !done, "R10 idle after reset", {cmd_valid, done}, 0);
  endtask

  task automatic t_release(input int L, input logic [15:0] S, input int H, input bit tog);
    int base, dprev;
    logic [15:0] rd, exp;
    @(negedge clk);
    stat_word = S; hr_limit = rd_seen + H; rdy_toggle = tog;
    base = lg_n; dprev = done_cnt;
    lane = 2'(L); start_release = 1'b1;
    @(negedge clk);
    start_release = 1'b0;
    wait_done(dprev);
    repeat (3) @(negedge clk);
    rd  = {S[15:1], (H > 0)};
    exp = rd & 16'hBFFF;
    chk(lg_n - base == 2, "R2 release command count", lg_n - base, 2);
    chk(!lg_wr[base] && lg_addr[base] == 16'(16'h2002 + L * 256), "R1 release read address",
        lg_addr[base], 16'h2002 + L * 256);
    chk(lg_wr[base+1] && lg_addr[base+1] == 16'(16'h2005 + L * 256), "R1 release write address",
        lg_addr[base+1], 16'h2005 + L * 256);
    chk(lg_data[base+1] == exp, "R2 release write data", lg_data[base+1], exp);
    chk(done_cyc - lg_cyc[base+1] == 1, "R2 done one cycle after write",
        done_cyc - lg_cyc[base+1], 1);
    chk(done_cnt == dprev + 1, "R7 single done pulse", done_cnt, dprev + 1);
    chk(poll_timeout == 1'b0, "R4 timeout cleared by new job", poll_timeout, 0);
  endtask

  task automatic t_force(input int L, input int M, input logic [15:0] S, input int H,
                         input bit tog, input bit both, input bit intrude);
    int base, dprev, np, rem, k;
    bit to, rd_ok;
    logic [15:0] w [0:4];
    @(negedge clk);
    stat_word = S; hr_limit = rd_seen + H; rdy_toggle = tog;
    base = lg_n; dprev = done_cnt;
    lane = 2'(L); mode = 3'(M); start_force = 1'b1; start_release = both;
    @(negedge clk);
    start_force = 1'b0; start_release = 1'b0;
    if (intrude) begin
      repeat (3) @(negedge clk);
      lane = 2'(L + 1); mode = 3'(M + 1); start_force = 1'b1; start_release = 1'b1;
      @(negedge clk);
      start_force = 1'b0; start_release = 1'b0;
    end
    wait_done(dprev);
    repeat (3) @(negedge clk);
    np  = (H < PL) ? H + 1 : PL;
    to  = (H >= PL);
    rem = H - ((H < np) ? H : np);
    w[0] = {S[15:1], (rem > 0)} & 16'hBFFF;
    w[1] = w[0] | 16'h4000;
    w[2] = (w[1] & 16'hF8FF) | 16'(M << 8);
    w[3] = w[2] | 16'h0800;
    w[4] = w[3] & 16'hF7FF;
    chk(lg_n - base == np + 6, "R3 R9 force command count", lg_n - base, np + 6);
    rd_ok = 1'b1;
    for (int i = 0; i <= np; i++)
      if (lg_wr[base+i] || lg_addr[base+i] != 16'(16'h2002 + L * 256)) rd_ok = 1'b0;
    chk(rd_ok, "R1 R3 poll and status reads", rd_ok, 1);
    for (int i = 0; i < 5; i++) begin
      k = base + np + 1 + i;
      chk(lg_wr[k] && lg_addr[k] == 16'(16'h2005 + L * 256) && lg_data[k] == w[i],
          $sformatf("R5 R6 override write %0d", i), lg_data[k], w[i]);
    end
    chk(poll_timeout == to, "R4 timeout flag", poll_timeout, to);
    k = base + np + 5;
    chk(done_cyc - lg_cyc[k] == ST + 1, "R7 settle delay", done_cyc - lg_cyc[k], ST + 1);
    chk(done_cnt == dprev + 1, "R7 single done pulse", done_cnt, dprev + 1);
  endtask

  initial begin
    bit wd;
    wd = 1'b0;
    fork
      begin
        t_reset();
        t_release(1, 16'h4F3C, 1, 1'b0);
        t_force(0, 3, 16'h1AA4, 0, 1'b0, 1'b0, 1'b0);
        t_force(3, 5, 16'hC0F0, 3, 1'b1, 1'b0, 1'b0);
        t_force(2, 7, 16'h4321, 100, 1'b0, 1'b0, 1'b0);
        chk(poll_timeout == 1'b1, "R4 timeout sticky while idle", poll_timeout, 1);
        t_release(2, 16'h7FFE, 0, 1'b1);
        t_force(1, 2, 16'h0000, 2, 1'b1, 1'b1, 1'b1);
        t_force(0, 6, 16'hFFFF, PL - 1, 1'b0, 1'b0, 1'b0);
        t_force(3, 1, 16'h0800, PL, 1'b1, 1'b0, 1'b0);
        chk(hold_err == 0, "R8 command hold under back-pressure", hold_err, 0);
      end
      begin
        repeat (100000) @(posedge clk);
        wd = 1'b1;
      end
    join_any
    if (wd) chk(1'b0, "watchdog expired", 1, 0);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule